// File: doc/BRIEF.md
# Branch Resolution and Next-PC Select

This combinational unit sits in the fetch path of a single-cycle 64-bit core. It receives the two source register values, a compact 2-bit comparison selector, a redirect control bit from the instruction decoder, a bit telling a jump from a conditional branch, the current PC, the sign-extended B-type immediate and a jump target. From these it reports whether a conditional branch is taken and produces the PC for the next instruction.

The branch target is formed inside the block as the current PC plus the immediate, so the unit can be checked on its own. Selection uses two levels of multiplexing. The inner level, driven by the comparison result, chooses between the branch target and the sequential address. The outer level, driven by the redirect bit, chooses between that inner result, the jump target and the sequential address. A greater-than branch needs no fourth comparator: software swaps the operands of less-than.

Top module: `brc_next_pc`

## Requirements
- R1: With selector code 00 the comparison is true exactly when the two operands are bit-for-bit equal.
- R2: With selector code 01 the comparison is true exactly when the two operands differ.
- R3: With selector code 10 the comparison is true exactly when the first operand is less than the second, both read as signed two's-complement values.
- R4: With selector code 11 the comparison is true exactly when the first operand is greater than or equal to the second, both read as signed two's-complement values.
- R5: `taken` is 1 only when redirect is 1, the instruction is a branch (`is_jump` = 0) and the selected comparison is true. Otherwise it is 0.
- R6: When redirect is 0, `pc_next` equals `pc_cur` + 4, whatever the operands, selector, kind bit, immediate and jump target are.
- R7: For a taken branch, `pc_next` equals `pc_cur` + `imm_b`. A negative immediate gives a lower address than `pc_cur`.
- R8: For a branch with redirect 1 whose comparison is false, `pc_next` equals `pc_cur` + 4.
- R9: When redirect is 1 and `is_jump` is 1, `pc_next` equals `jump_tgt`, whatever the comparison gives.
- R10: Both PC additions wrap modulo 2^64. For example, `pc_cur` = 0xFFFF_FFFF_FFFF_FFFC gives a sequential PC of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 64 | First source register value |
| opnd_b | input | 64 | Second source register value |
| cmp_sel | input | 2 | Comparison selector: 00 eq, 01 ne, 10 signed lt, 11 signed ge |
| redirect_en | input | 1 | Decoder request to leave the sequential path |
| is_jump | input | 1 | 1 = unconditional jump, 0 = conditional branch |
| pc_cur | input | 64 | Address of the current instruction |
| imm_b | input | 64 | Sign-extended branch offset |
| jump_tgt | input | 64 | Target address of a jump |
| taken | output | 1 | The branch is taken |
| pc_next | output | 64 | Address of the next instruction |

## Verification
The hardest cases to reach are those where the signed and unsigned orderings disagree. Examples are a negative operand against a positive one, and the most negative value against the most positive. A comparator that is wrongly unsigned gives the right answer on small positive operands and fails only on these. The directed tasks therefore pair sign-bit-set operands with sign-bit-clear ones under both less-than and greater-or-equal. They also drive jumps whose comparison is true and false, and redirect-off cycles with a comparison that is true, so that every path through the two mux levels is seen.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_NE = 2'b01,
    CMP_LT = 2'b10,
    CMP_GE = 2'b11
  } cmp_sel_e;
endpackage

// File: rtl/brc_compare.sv
module brc_compare
  import brc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter bit SHARED_SUB = 1'b1
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [1:0]      sel,
  output logic            hit
);
  logic eq_w;
  logic lt_w;

  assign eq_w = (a == b);

  generate
    if (SHARED_SUB) begin : g_sub
      // One sign-extended subtractor; the borrow-free sign bit gives signed lt.
      logic [XLEN:0] diff;
      assign diff = {a[XLEN-1], a} - {b[XLEN-1], b};
      assign lt_w = diff[XLEN];
    end else begin : g_cmp
      assign lt_w = ($signed(a) < $signed(b));
    end
  endgenerate

  always_comb begin
    unique case (cmp_sel_e'(sel))
      CMP_EQ:  hit = eq_w;
      CMP_NE:  hit = ~eq_w;
      CMP_LT:  hit = lt_w;
      CMP_GE:  hit = ~lt_w;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int XLEN       = 64,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] offset,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] br_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  assign seq_pc = pc + STEP;
  assign br_pc  = pc + offset;
endmodule

// File: rtl/brc_pc_mux.sv
module brc_pc_mux #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] br_pc,
  input  logic [XLEN-1:0] jmp_pc,
  input  logic            br_hit,
  input  logic            redirect,
  input  logic            jump,
  output logic [XLEN-1:0] nxt_pc
);
  logic [XLEN-1:0] inner_pc;

  assign inner_pc = br_hit ? br_pc : seq_pc;

  always_comb begin
    if (!redirect)  nxt_pc = seq_pc;
    else if (jump)  nxt_pc = jmp_pc;
    else            nxt_pc = inner_pc;
  end
endmodule

// File: rtl/brc_next_pc.sv
module brc_next_pc #(
  parameter int XLEN       = 64,
  parameter int INSN_BYTES = 4,
  parameter bit SHARED_SUB = 1'b1
) (
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [1:0]      cmp_sel,
  input  logic            redirect_en,
  input  logic            is_jump,
  input  logic [XLEN-1:0] pc_cur,
  input  logic [XLEN-1:0] imm_b,
  input  logic [XLEN-1:0] jump_tgt,
  output logic            taken,
  output logic [XLEN-1:0] pc_next
);
  logic            cmp_hit;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_pc;

  brc_compare #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cmp (
    .a   (opnd_a),
    .b   (opnd_b),
    .sel (cmp_sel),
    .hit (cmp_hit)
  );

  brc_target #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_tgt (
    .pc     (pc_cur),
    .offset (imm_b),
    .seq_pc (seq_pc),
    .br_pc  (br_pc)
  );

  assign taken = redirect_en & ~is_jump & cmp_hit;

  brc_pc_mux #(.XLEN(XLEN)) u_mux (
    .seq_pc   (seq_pc),
    .br_pc    (br_pc),
    .jmp_pc   (jump_tgt),
    .br_hit   (cmp_hit),
    .redirect (redirect_en),
    .jump     (is_jump),
    .nxt_pc   (pc_next)
  );
endmodule

// File: rtl/brc_next_pc_chk.sv
module brc_next_pc_chk #(
  parameter int XLEN       = 64,
  parameter int INSN_BYTES = 4
) (
  input logic [XLEN-1:0] opnd_a,
  input logic [XLEN-1:0] opnd_b,
  input logic [1:0]      cmp_sel,
  input logic            redirect_en,
  input logic            is_jump,
  input logic [XLEN-1:0] pc_cur,
  input logic [XLEN-1:0] imm_b,
  input logic [XLEN-1:0] jump_tgt,
  input logic            taken,
  input logic [XLEN-1:0] pc_next
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic known;
  assign known = !$isunknown({opnd_a, opnd_b, cmp_sel, redirect_en, is_jump,
                              pc_cur, imm_b, jump_tgt, taken, pc_next});

  always_comb begin
    if (known) begin
      p_idle_not_taken_r5: assert (redirect_en || !taken);
      p_jump_not_taken_r5: assert (!is_jump || !taken);
      p_idle_seq_r6: assert (redirect_en || pc_next == pc_cur + STEP);
      p_jump_tgt_r9: assert (!(redirect_en && is_jump) || pc_next == jump_tgt);
      p_br_taken_r7: assert (!taken || pc_next == pc_cur + imm_b);
      p_br_fall_r8: assert (!(redirect_en && !is_jump && !taken)
                            || pc_next == pc_cur + STEP);
      p_eq_r1: assert (!(redirect_en && !is_jump && cmp_sel == 2'b00)
                       || taken == (opnd_a == opnd_b));
      p_ne_r2: assert (!(redirect_en && !is_jump && cmp_sel == 2'b01)
                       || taken == (opnd_a != opnd_b));
      p_lt_r3: assert (!(redirect_en && !is_jump && cmp_sel == 2'b10)
                       || taken == ($signed(opnd_a) < $signed(opnd_b)));
      p_ge_r4: assert (!(redirect_en && !is_jump && cmp_sel == 2'b11)
                       || taken == ($signed(opnd_a) >= $signed(opnd_b)));
    end
  end
endmodule

bind brc_next_pc brc_next_pc_chk #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_chk (
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .cmp_sel     (cmp_sel),
  .redirect_en (redirect_en),
  .is_jump     (is_jump),
  .pc_cur      (pc_cur),
  .imm_b       (imm_b),
  .jump_tgt    (jump_tgt),
  .taken       (taken),
  .pc_next     (pc_next)
);

// File: tb/brc_next_pc_bench.sv
`timescale 1ns/1ps
module brc_next_pc_bench;
  logic        clk;
  logic        rst_n;
  logic [63:0] opnd_a, opnd_b, pc_cur, imm_b, jump_tgt;
  logic [1:0]  cmp_sel;
  logic        redirect_en, is_jump;
  logic        taken;
  logic [63:0] pc_next;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  brc_next_pc u_brc_next_pc (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .cmp_sel(cmp_sel),
    .redirect_en(redirect_en), .is_jump(is_jump), .pc_cur(pc_cur),
    .imm_b(imm_b), .jump_tgt(jump_tgt), .taken(taken), .pc_next(pc_next)
  );

  task automatic chk_bit(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s taken act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic chk_pc(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pc_next act=%h exp=%h", req, act, exp);
    end
  endtask

  // Drive after a rising edge, sample mid-cycle on the falling edge.
  task automatic apply(logic [63:0] a, logic [63:0] b, logic [1:0] sel,
                       logic red, logic jmp, logic [63:0] pc,
                       logic [63:0] imm, logic [63:0] jt);
    @(posedge clk);
    opnd_a = a; opnd_b = b; cmp_sel = sel; redirect_en = red;
    is_jump = jmp; pc_cur = pc; imm_b = imm; jump_tgt = jt;
    @(negedge clk);
  endtask

  // Branch with expected comparison outcome computed from the requirement.
  task automatic branch(string req, logic [63:0] a, logic [63:0] b,
                        logic [1:0] sel, logic [63:0] pc, logic [63:0] imm);
    logic hit;
    case (sel)
      2'b00:   hit = (a == b);
      2'b01:   hit = (a != b);
      2'b10:   hit = ($signed(a) <  $signed(b));
      default: hit = ($signed(a) >= $signed(b));
    endcase
    apply(a, b, sel, 1'b1, 1'b0, pc, imm, 64'hDEAD_0000);
    chk_bit(req, taken, hit);
    chk_pc(hit ? {req, "/R7"} : {req, "/R8"}, pc_next, hit ? pc + imm : pc + 64'd4);
  endtask

  task automatic t_reset_state;
    chk_bit("R5", taken, 1'b0);
    chk_pc("R6", pc_next, 64'd4);
  endtask

  task automatic t_equal;  // R1
    branch("R1", 64'd7, 64'd7, 2'b00, 64'h100, 64'd32);
    branch("R1", 64'd7, 64'd8, 2'b00, 64'h100, 64'd32);
    branch("R1", 64'h8000_0000_0000_0000, 64'h0, 2'b00, 64'h200, 64'd16);
  endtask

  task automatic t_not_equal;  // R2
    branch("R2", 64'd5, 64'd9, 2'b01, 64'h300, 64'd64);
    branch("R2", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 64'h300, 64'd64);
  endtask

  task automatic t_less;  // R3 signed
    branch("R3", 64'd3, 64'd9, 2'b10, 64'h400, 64'd8);
    branch("R3", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 2'b10, 64'h400, 64'd8);
    branch("R3", 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 2'b10, 64'h400, 64'd8);
    branch("R3", 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 2'b10, 64'h400, 64'd8);
    branch("R3", 64'd9, 64'd9, 2'b10, 64'h400, 64'd8);
  endtask

  task automatic t_greater_eq;  // R4 signed
    branch("R4", 64'd9, 64'd9, 2'b11, 64'h500, 64'd12);
    branch("R4", 64'hFFFF_FFFF_FFFF_FFF0, 64'd2, 2'b11, 64'h500, 64'd12);
    branch("R4", 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 2'b11, 64'h500, 64'd12);
  endtask

  task automatic t_backward;  // R7: 0x40 + (-16) = 0x30
    apply(64'd0, 64'd0, 2'b00, 1'b1, 1'b0, 64'h40, -64'sd16, 64'h0);
    chk_bit("R7", taken, 1'b1);
    chk_pc("R7", pc_next, 64'h30);
  endtask

  task automatic t_redirect_off;  // R5, R6: comparison true but no redirect
    apply(64'd1, 64'd1, 2'b00, 1'b0, 1'b0, 64'h1000, 64'h80, 64'h9000);
    chk_bit("R5", taken, 1'b0);
    chk_pc("R6", pc_next, 64'h1004);
    apply(64'd1, 64'd1, 2'b00, 1'b0, 1'b1, 64'h2000, 64'h80, 64'h9000);
    chk_bit("R5", taken, 1'b0);
    chk_pc("R6", pc_next, 64'h2004);
  endtask

  task automatic t_jump;  // R9, R5
    apply(64'd1, 64'd2, 2'b00, 1'b1, 1'b1, 64'h600, 64'h40, 64'hABC0);
    chk_pc("R9", pc_next, 64'hABC0);
    chk_bit("R5", taken, 1'b0);
    apply(64'd4, 64'd4, 2'b00, 1'b1, 1'b1, 64'h600, 64'h40, 64'h0120);
    chk_pc("R9", pc_next, 64'h0120);
    chk_bit("R5", taken, 1'b0);
  endtask

  task automatic t_wrap;  // R10
    apply(64'd0, 64'd0, 2'b01, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 64'h0);
    chk_pc("R10", pc_next, 64'h0);
    apply(64'd0, 64'd1, 2'b01, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFF8, 64'h10, 64'h0);
    chk_pc("R10", pc_next, 64'h8);
  endtask

  initial begin
    rst_n = 1'b0;
    opnd_a = '0; opnd_b = '0; cmp_sel = '0; redirect_en = 1'b0;
    is_jump = 1'b0; pc_cur = '0; imm_b = '0; jump_tgt = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_equal();
    t_not_equal();
    t_less();
    t_greater_eq();
    t_backward();
    t_redirect_off();
    t_jump();
    t_wrap();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule